// File: doc/BRIEF.md
# Approximate Triple-Voted Adder

This block is a purely combinational adder for error-tolerant datapaths. It adds two N-bit operands and produces an (N+1)-bit sum. Three identical copies of an approximate adder compute the sum, and a bitwise two-out-of-three voter combines their outputs into the result. Any single faulty copy is therefore hidden, as it would be in plain triplication. The saving is in each copy's lower L bits: that slice is simplified instead of exact, so the triplicated hardware is smaller than three exact adders.

Each copy is split into two slices. The upper slice, bits N-1 down to L, is an exact adder. It gets a carry-in made from a single AND of the top operand bits of the lower slice. In the lower slice, the four highest bits are each the OR of the two operand bits. Every bit below those four is tied to logic 1.

For test, each copy's raw output passes through an XOR fault mask before it reaches the voter. A zero mask leaves the copy untouched. Any set bit flips that output bit of that copy only.

Top module: `apx_tmr_adder`

## Requirements
- R1: With all masks zero, sum_o[N:L] equals op_a[N-1:L] + op_b[N-1:L] + carry, where carry is op_a[L-1] AND op_b[L-1], computed exactly to N-L+1 bits.
- R2: The only link from the lower slice to the upper slice is op_a[L-1] AND op_b[L-1]. A carry that an exact adder would produce from lower operand bits below L-1 never reaches the upper slice.
- R3: With all masks zero, each of sum_o[L-1:L-4] equals the OR of the operand bits at the same position.
- R4: With all masks zero, sum_o[L-5:0] are all 1 for every pair of operands.
- R5: Each bit of sum_o is the majority of that bit across the three masked copies. A bit that is flipped in two or in all three copies appears flipped at the output.
- R6: With any mask value on exactly one copy and zero masks on the other two, sum_o equals the fault-free approximate sum.
- R7: Faults spread over several copies are masked whenever no output bit is flipped in more than one copy.
- R8: sum_o[N] carries the carry-out of the upper slice. With both operands all ones and no faults, every one of the N+1 sum bits is 1.
- R9: The parameters must satisfy L >= 5 and N > L. The defaults are N = 32 and L = 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| flt_mask0 | input | N+1 | XOR fault mask applied to copy 0's output |
| flt_mask1 | input | N+1 | XOR fault mask applied to copy 1's output |
| flt_mask2 | input | N+1 | XOR fault mask applied to copy 2's output |
| sum_o | output | N+1 | Voted approximate sum |

## Verification
The bench builds the block with the default N = 32 and L = 10. With these values the 22-bit exact slice, the four OR bits and the six tied bits each hold several bits, so every field boundary can be seen at the output. A walking single-bit fault is placed on every one of the 33 output bits of every copy, which confirms the masking at every voter position. Hand-picked operands isolate the link carry, the OR bits, the tied bits and the top carry-out. Random operand and mask patterns then test multi-copy faults: disjoint flips must be hidden, while flips on the same bit in two or three copies must show at the output.

// File: rtl/apx_tmr_pkg.sv
package apx_tmr_pkg;

    localparam int COPIES  = 3;
    localparam int RED_BITS = 4;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction

endpackage

// File: rtl/apx_lower_slice.sv
module apx_lower_slice #(
    parameter int L = 10
) (
    input  logic [L-1:0] a_lo,
    input  logic [L-1:0] b_lo,
    output logic [L-1:0] sum_lo,
    output logic         link_o
);
    import apx_tmr_pkg::*;

    localparam int TIE = L - RED_BITS;

    typedef struct packed {
        logic [L-1:0] bits;
        logic         link;
    } lo_t;

    lo_t lo_d;

    always_comb begin
        lo_d.bits = '1;
        for (int i = TIE; i < L; i++) begin
            lo_d.bits[i] = a_lo[i] | b_lo[i];
        end
        lo_d.link = a_lo[L-1] & b_lo[L-1];
    end

    assign sum_lo = lo_d.bits;
    assign link_o = lo_d.link;

endmodule

// File: rtl/apx_upper_slice.sv
module apx_upper_slice #(
    parameter int W = 22
) (
    input  logic [W-1:0] a_hi,
    input  logic [W-1:0] b_hi,
    input  logic         cin,
    output logic [W:0]   sum_hi
);
    typedef struct packed {
        logic [W:0] sum;
    } hi_t;

    hi_t hi_d;

    always_comb begin
        hi_d.sum = {1'b0, a_hi} + {1'b0, b_hi} + {{W{1'b0}}, cin};
    end

    assign sum_hi = hi_d.sum;

endmodule

// File: rtl/apx_copy.sv
module apx_copy #(
    parameter int N = 32,
    parameter int L = 10
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N:0]   sum
);
    localparam int HW = N - L;

    logic [L-1:0] lo_sum;
    logic [HW:0]  hi_sum;
    logic         link;

    apx_lower_slice #(.L(L)) u_lo (
        .a_lo   (a[L-1:0]),
        .b_lo   (b[L-1:0]),
        .sum_lo (lo_sum),
        .link_o (link)
    );

    apx_upper_slice #(.W(HW)) u_hi (
        .a_hi   (a[N-1:L]),
        .b_hi   (b[N-1:L]),
        .cin    (link),
        .sum_hi (hi_sum)
    );

    assign sum = {hi_sum, lo_sum};

endmodule

// File: rtl/maj_voter.sv
module maj_voter #(
    parameter int W = 33
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] f
);
    import apx_tmr_pkg::*;

    typedef struct packed {
        logic [W-1:0] vote;
    } vt_t;

    vt_t vt_d;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            vt_d.vote[i] = maj3(x[i], y[i], z[i]);
        end
    end

    assign f = vt_d.vote;

    // two agreeing inputs decide the bit
    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (x[i] == y[i] || x[i] == z[i]) begin
                p_vote_agree_r5: assert (f[i] == x[i])
                    else $error("voter bit %0d disagrees with majority", i);
            end else begin
                p_vote_pair_r5: assert (f[i] == y[i])
                    else $error("voter bit %0d disagrees with y/z pair", i);
            end
        end
    end

endmodule

// File: rtl/apx_tmr_adder.sv
module apx_tmr_adder #(
    parameter int N = 32,
    parameter int L = 10
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [N:0]   flt_mask0,
    input  logic [N:0]   flt_mask1,
    input  logic [N:0]   flt_mask2,
    output logic [N:0]   sum_o
);
    import apx_tmr_pkg::*;

    localparam int W   = N + 1;
    localparam int HW  = N - L;
    localparam int TIE = L - RED_BITS;

    initial begin
        p_param_split_r9: assert (L >= 5 && N > L)
            else $error("invalid split N=%0d L=%0d", N, L);
    end

    logic [W-1:0] raw  [COPIES];
    logic [W-1:0] mask [COPIES];
    logic [W-1:0] hit  [COPIES];

    assign mask[0] = flt_mask0;
    assign mask[1] = flt_mask1;
    assign mask[2] = flt_mask2;

    generate
        for (genvar k = 0; k < COPIES; k++) begin : g_copy
            apx_copy #(.N(N), .L(L)) u_copy (
                .a   (op_a),
                .b   (op_b),
                .sum (raw[k])
            );
            assign hit[k] = raw[k] ^ mask[k];
        end
    endgenerate

    maj_voter #(.W(W)) u_vote (
        .x (hit[0]),
        .y (hit[1]),
        .z (hit[2]),
        .f (sum_o)
    );

    // checks relating copies, voter and ports
    logic [COPIES-1:0] m_any;
    logic [W-1:0]      clean_ref;
    logic [HW:0]       hi_ref;

    always_comb begin
        for (int k = 0; k < COPIES; k++) m_any[k] = |mask[k];
        clean_ref = m_any[0] ? raw[1] : raw[0];
        hi_ref    = {1'b0, op_a[N-1:L]} + {1'b0, op_b[N-1:L]}
                  + {{HW{1'b0}}, (op_a[L-1] & op_b[L-1])};

        if ($onehot0(m_any)) begin
            p_single_copy_masked_r6: assert (sum_o == clean_ref)
                else $error("single-copy fault leaked to output");
        end
        if (m_any == '0) begin
            p_upper_exact_r1: assert (sum_o[N:L] == hi_ref)
                else $error("upper slice mismatch");
            p_or_bits_r3: assert (sum_o[L-1:TIE] == (op_a[L-1:TIE] | op_b[L-1:TIE]))
                else $error("reduced bits mismatch");
            p_tied_ones_r4: assert (&sum_o[TIE-1:0])
                else $error("tied bits not all ones");
            if (op_a[N-1:L] == '0 && op_b[N-1:L] == '0) begin
                p_slice_link_r2: assert (sum_o[L] == (op_a[L-1] & op_b[L-1]))
                    else $error("slice link carry mismatch");
            end
        end
    end

endmodule

// File: tb/sim_apx_tmr_adder.sv
module sim_apx_tmr_adder;
    localparam int N = 32;
    localparam int L = 10;
    localparam int W = N + 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0] a = '0, b = '0;
    logic [W-1:0] m0 = '0, m1 = '0, m2 = '0;
    logic [W-1:0] sum;

    apx_tmr_adder #(.N(N), .L(L)) u0 (
        .op_a(a), .op_b(b),
        .flt_mask0(m0), .flt_mask1(m1), .flt_mask2(m2),
        .sum_o(sum)
    );

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    function automatic logic [W-1:0] model(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [W-1:0] r;
        logic [N-L:0] hi;
        hi = {1'b0, x[N-1:L]} + {1'b0, y[N-1:L]} + {{(N-L){1'b0}}, (x[L-1] & y[L-1])};
        r = '1;
        r[N:L] = hi;
        r[L-1:L-4] = x[L-1:L-4] | y[L-1:L-4];
        return r;
    endfunction

    function automatic logic [W-1:0] voted(input logic [W-1:0] e, input logic [W-1:0] x0,
                                           input logic [W-1:0] x1, input logic [W-1:0] x2);
        logic [W-1:0] p, r, s;
        p = e ^ x0; r = e ^ x1; s = e ^ x2;
        return (p & r) | (r & s) | (p & s);
    endfunction

    task automatic drive(input logic [N-1:0] aa, input logic [N-1:0] bb,
                         input logic [W-1:0] x0, input logic [W-1:0] x1,
                         input logic [W-1:0] x2, input logic [W-1:0] e, input string tag);
        item_t it;
        @(posedge clk);
        a = aa; b = bb; m0 = x0; m1 = x1; m2 = x2;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic drive_m(input logic [N-1:0] aa, input logic [N-1:0] bb,
                           input logic [W-1:0] x0, input logic [W-1:0] x1,
                           input logic [W-1:0] x2, input string tag);
        drive(aa, bb, x0, x1, x2, voted(model(aa, bb), x0, x1, x2), tag);
    endtask

    function automatic logic [W-1:0] rmask();
        return {1'($urandom % 2), 32'($urandom)};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: compare one item per cycle, away from the drive edge
    always @(negedge clk) begin
        item_t it;
        if (q.size() > 0) begin
            it = q.pop_front();
            n_cmp++;
            if (sum !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, sum, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // idle state with zero inputs: only the tied bits are high (R4)
        drive('0, '0, '0, '0, '0, 33'h0_0000003F, "R4 zero operands");
        // low operand bits set: tied bits still one, no carry out of them (R4, R2)
        drive(32'h0000003F, 32'h0000003F, '0, '0, '0, 33'h0_0000003F, "R4 R2 low bits ignored");
        // link carry from top lower bits (R2)
        drive(32'h00000200, 32'h00000200, '0, '0, '0, 33'h0_0000063F, "R2 link carry");
        // OR bits (R3)
        drive(32'h00000140, 32'h00000080, '0, '0, '0, 33'h0_000001FF, "R3 or bits");
        drive(32'h000003C0, 32'h000003C0, '0, '0, '0, 33'h0_000007FF, "R3 R2 or bits with link");
        // top carry-out (R8)
        drive(32'hFFFFFFFF, 32'hFFFFFFFF, '0, '0, '0, 33'h1_FFFFFFFF, "R8 all ones");
        drive(32'h80000000, 32'h80000000, '0, '0, '0, 33'h1_0000003F, "R8 carry out");
        // random operands, no faults (R1)
        for (int i = 0; i < 200; i++)
            drive_m($urandom, $urandom, '0, '0, '0, "R1 random exact upper");
        // whole faulty copy (R6)
        for (int i = 0; i < 20; i++) begin
            drive_m($urandom, $urandom, '1, '0, '0, "R6 copy0 dead");
            drive_m($urandom, $urandom, '0, '1, '0, "R6 copy1 dead");
            drive_m($urandom, $urandom, '0, '0, rmask(), "R6 copy2 random");
        end
        // walking single fault over every bit of every copy (R6)
        for (int bit_i = 0; bit_i < W; bit_i++) begin
            drive_m($urandom, $urandom, W'(1) << bit_i, '0, '0, "R6 walk copy0");
            drive_m($urandom, $urandom, '0, W'(1) << bit_i, '0, "R6 walk copy1");
            drive_m($urandom, $urandom, '0, '0, W'(1) << bit_i, "R6 walk copy2");
        end
        // disjoint faults over several copies (R7)
        drive_m($urandom, $urandom, 33'h0_55555555, 33'h1_AAAAAAAA, '0, "R7 disjoint pair");
        drive_m($urandom, $urandom, 33'h0_000007FF, 33'h0_003FF800, 33'h1_FFC00000, "R7 disjoint triple");
        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] x0, x1;
            x0 = rmask();
            x1 = rmask() & ~x0;
            drive_m($urandom, $urandom, x0, x1, ~(x0 | x1) & rmask(), "R7 random disjoint");
        end
        // same bit in two or three copies flips the output (R5)
        drive(32'h0, 32'h0, 33'h1_00000000, 33'h1_00000000, '0, 33'h1_0000003F, "R5 two copies flip top");
        drive(32'h0, 32'h0, 33'h0_00000001, 33'h0_00000001, 33'h0_00000001, 33'h0_0000003E, "R5 three copies flip bit0");
        for (int i = 0; i < 30; i++)
            drive_m($urandom, $urandom, rmask(), rmask(), rmask(), "R5 random overlapping");
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        ended = 1;
        finish_run();
    end

endmodule